// File: doc/BRIEF.md
# Memory-mapped flash read engine

This block lets a processor bus read a serial NOR flash as if it were memory. Each accepted bus read at an offset becomes one complete flash read transaction: chip select goes low, a read opcode goes out, then a programmable number of address bytes taken from the offset, then a programmable number of dummy bytes. One 32-bit word is then clocked in on one, two or four data lines. Chip select is released and the word comes back with a one-cycle valid pulse.

The framing of the transaction comes from a setup word per chip select, supplied by an external register file. A mapping-enable input switches the port into this mode. While it is set, or while a mapped read is in flight, register-driven transfers must stay off the pins, and the block reports this on a permission output. A 3-bit routing field picks the chip select the window drives. A read arriving with the mode off, or with no valid chip select routed, is answered at once with an error and zero data. No pin moves for such a read.

Top module: `flash_map_reader`

## Requirements
- R1: After reset, all chip selects are high, sclk_o is low, rsp_valid_o is low and req_ready_o is high.
- R2: cs_route_i holds the chip-select index plus one. A value k from 1 to NUM_CS drives cs_n_o[k-1] low for the read. A value of 0, or one above NUM_CS, selects nothing.
- R3: A read is accepted while map_en_i is low, or while no chip select is selected. It yields rsp_valid_o with rsp_err_o high and rsp_data_o zero in the cycle after acceptance, with no chip select low and no sclk_o edge.
- R4: A mapped read first sends the 8-bit opcode from setup bits 7:0. It then sends (setup bits 9:8)+1 address bytes, which are the low bytes of the offset with the most significant byte first; offset bits at or above ADDR_W count as zero. Then come (setup bits 11:10) dummy bytes. All of these go MSB first on io_o[0] alone, with io_oe_o = 4'b0001.
- R5: Setup bits 13:12 choose the data phase. 0 gives single line on io_i[1] for 32 clocks, 1 gives dual on io_i[1:0] for 16 clocks, 3 gives quad on io_i[3:0] for 8 clocks, and 2 acts as single. No output is enabled in the data phase, and no extra sclk_o pulse follows it.
- R6: The first data bit received ends up in rsp_data_o[31]. Within one clock, the higher-numbered line carries the more significant bit.
- R7: The serial clock is mode 0. sclk_o idles low, outputs change after its falling edge and inputs are sampled on its rising edge. Each level lasts HALF_DIV clk_i cycles.
- R8: setup_i bits [16n+15:16n] frame reads on chip select n. The setup word and the route are taken at acceptance, so later changes do not affect a read in flight.
- R9: A mapped read ends with a single rsp_valid_o pulse, with rsp_err_o low, in the cycle chip select is released. req_ready_o stays low from acceptance until HALF_DIV cycles after that pulse.
- R10: direct_allow_o is high only while map_en_i is low and no mapped read is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_en_i | input | 1 | Memory-mapped mode enable |
| cs_route_i | input | 3 | Chip select driven by the window, index plus one, 0 for none |
| setup_i | input | NUM_CS*16 | Setup word per chip select, slot n at bits 16n+15:16n |
| req_valid_i | input | 1 | Bus read request |
| req_addr_i | input | ADDR_W | Bus read offset |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Response is an error, data zero |
| rsp_data_o | output | 32 | Read word |
| direct_allow_o | output | 1 | Register-driven transfers may use the pins |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| io_o | output | 4 | Serial data out |
| io_oe_o | output | 4 | Output enable per data line |
| io_i | input | 4 | Serial data in |

## Verification
The bench builds the block with NUM_CS = 3, HALF_DIV = 2 and ADDR_W = 24. Three chip selects leave route values 4 to 7 in the field unused, so the out-of-range error path can be reached. A 24-bit offset makes a four-byte address send a zero top byte, which checks the padding rule. A half period of two clocks leaves a distinct cycle between each sclk edge and the sample point. This lets a flash model in the bench check the level widths, the drive-on-fall and sample-on-rise order, and the number of data clocks in every lane mode.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  localparam int SETUP_W = 16;
  localparam int WORD_W  = 32;
  localparam int ROUTE_W = 3;
  localparam int LINES   = 4;
  // opcode + up to 4 address bytes + up to 3 dummy bytes
  localparam int TX_MAX  = 8 + 8 * 4 + 8 * 3;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [2:0] addr_bytes;   // 1..4
    logic [1:0] dummy_bytes;  // 0..3
    lane_e      lane;
  } frame_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } state_e;
endpackage

// File: rtl/fmr_route_decode.sv
module fmr_route_decode
  import fmr_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      map_en_i,
  input  logic [ROUTE_W-1:0]        route_i,
  input  logic [NUM_CS*SETUP_W-1:0] setup_i,
  output logic                      sel_ok_o,
  output logic [IDX_W-1:0]          sel_idx_o,
  output frame_cfg_t                cfg_o
);
  logic [SETUP_W-1:0] slot [NUM_CS];
  logic [SETUP_W-1:0] word;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_slot
    assign slot[n] = setup_i[n*SETUP_W +: SETUP_W];
  end

  assign sel_ok_o  = map_en_i && (route_i != '0) && (32'(route_i) <= NUM_CS);
  assign sel_idx_o = IDX_W'(route_i - ROUTE_W'(1));

  always_comb begin
    word = '0;
    for (int n = 0; n < NUM_CS; n++) begin
      if (IDX_W'(n) == sel_idx_o) word = slot[n];
    end
  end

  always_comb begin
    cfg_o.opcode      = word[7:0];
    cfg_o.addr_bytes  = {1'b0, word[9:8]} + 3'd1;
    cfg_o.dummy_bytes = word[11:10];
    unique case (word[13:12])
      2'd1:    cfg_o.lane = LANE_X2;
      2'd3:    cfg_o.lane = LANE_X4;
      default: cfg_o.lane = LANE_X1;
    endcase
  end
endmodule

// File: rtl/fmr_sclk_tick.sv
module fmr_sclk_tick #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [CW-1:0] hc_q;

  assign tick_o = run_i && (hc_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hc_q <= '0;
    else if (!run_i || tick_o)  hc_q <= '0;
    else                        hc_q <= hc_q + CW'(1);
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> hc_q == '0); // R7
endmodule

// File: rtl/fmr_serdes.sv
module fmr_serdes
  import fmr_pkg::*;
#(
  localparam int CYC_W = $clog2(TX_MAX + WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  frame_cfg_t        cfg_i,
  input  logic [31:0]       addr_i,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic [LINES-1:0]  io_i,
  output logic [LINES-1:0]  io_o,
  output logic [LINES-1:0]  io_oe_o,
  output logic              sclk_o,
  output logic              last_o,
  output logic [WORD_W-1:0] word_o
);
  logic [TX_MAX-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [CYC_W-1:0]  cyc_q, txb_q, tot_q;
  logic [CYC_W-1:0]  txb_c, dcy_c;
  lane_e             lane_q;
  logic              sclk_q;
  logic              in_data;
  logic [31:0]       addr_al;

  assign addr_al = addr_i << {3'd4 - cfg_i.addr_bytes, 3'b000};
  assign txb_c   = CYC_W'(8) + CYC_W'({cfg_i.addr_bytes, 3'b000})
                 + CYC_W'({cfg_i.dummy_bytes, 3'b000});

  always_comb begin
    unique case (cfg_i.lane)
      LANE_X2: dcy_c = CYC_W'(WORD_W / 2);
      LANE_X4: dcy_c = CYC_W'(WORD_W / 4);
      default: dcy_c = CYC_W'(WORD_W);
    endcase
  end

  assign in_data = cyc_q >= txb_q;
  assign last_o  = active_i && tick_i && sclk_q && (cyc_q == tot_q - CYC_W'(1));
  assign sclk_o  = sclk_q;
  assign word_o  = rx_q;
  assign io_o    = {{(LINES-1){1'b0}}, tx_q[TX_MAX-1]};
  assign io_oe_o = (active_i && !in_data) ? LINES'(1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cyc_q  <= '0;
      txb_q  <= CYC_W'(8);
      tot_q  <= CYC_W'(8);
      lane_q <= LANE_X1;
      sclk_q <= 1'b0;
    end else if (load_i) begin
      tx_q   <= {cfg_i.opcode, addr_al, {(TX_MAX-40){1'b0}}};
      rx_q   <= '0;
      cyc_q  <= '0;
      txb_q  <= txb_c;
      tot_q  <= txb_c + dcy_c;
      lane_q <= cfg_i.lane;
      sclk_q <= 1'b0;
    end else if (active_i && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        if (in_data) begin
          unique case (lane_q)
            LANE_X2: rx_q <= {rx_q[WORD_W-3:0], io_i[1:0]};
            LANE_X4: rx_q <= {rx_q[WORD_W-5:0], io_i[3:0]};
            default: rx_q <= {rx_q[WORD_W-2:0], io_i[1]};
          endcase
        end
      end else begin
        sclk_q <= 1'b0;
        if (!last_o) begin
          cyc_q <= cyc_q + CYC_W'(1);
          tx_q  <= {tx_q[TX_MAX-2:0], 1'b0};
        end
      end
    end
  end

  AST_CYC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cyc_q < tot_q); // R5
  AST_RX_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !$rose(sclk_q) && !load_i |-> $stable(rx_q) || $past(load_i)); // R7
endmodule

// File: rtl/flash_map_reader.sv
module flash_map_reader
  import fmr_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      map_en_i,
  input  logic [ROUTE_W-1:0]        cs_route_i,
  input  logic [NUM_CS*SETUP_W-1:0] setup_i,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      req_ready_o,
  output logic                      rsp_valid_o,
  output logic                      rsp_err_o,
  output logic [WORD_W-1:0]         rsp_data_o,
  output logic                      direct_allow_o,
  output logic                      sclk_o,
  output logic [NUM_CS-1:0]         cs_n_o,
  output logic [LINES-1:0]          io_o,
  output logic [LINES-1:0]          io_oe_o,
  input  logic [LINES-1:0]          io_i
);
  state_e          state_q;
  logic [IDX_W-1:0] cs_idx_q;
  logic            sel_ok;
  logic [IDX_W-1:0] sel_idx;
  frame_cfg_t      cfg;
  logic            accept, load, tick, last;
  logic [WORD_W-1:0] word;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign load   = accept && sel_ok;

  fmr_route_decode #(.NUM_CS(NUM_CS)) u_dec (
    .map_en_i (map_en_i),
    .route_i  (cs_route_i),
    .setup_i  (setup_i),
    .sel_ok_o (sel_ok),
    .sel_idx_o(sel_idx),
    .cfg_o    (cfg)
  );

  fmr_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick)
  );

  fmr_serdes u_sd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .cfg_i   (cfg),
    .addr_i  (32'(req_addr_i)),
    .active_i(state_q == ST_RUN),
    .tick_i  (tick),
    .io_i    (io_i),
    .io_o    (io_o),
    .io_oe_o (io_oe_o),
    .sclk_o  (sclk_o),
    .last_o  (last),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cs_idx_q    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (sel_ok) begin
            state_q  <= ST_RUN;
            cs_idx_q <= sel_idx;
          end else begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b1;
            rsp_data_o  <= '0;
          end
        end
        ST_RUN: if (last) begin
          state_q     <= ST_GAP;
          rsp_valid_o <= 1'b1;
          rsp_err_o   <= 1'b0;
          rsp_data_o  <= word;
        end
        ST_GAP: if (tick) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_n_o[n] = !((state_q == ST_RUN) && (cs_idx_q == IDX_W'(n)));
  end

  assign req_ready_o    = state_q == ST_IDLE;
  assign direct_allow_o = !map_en_i && (state_q == ST_IDLE);

  AST_ERR_NO_SPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !sel_ok |=> rsp_valid_o && rsp_err_o && (rsp_data_o == '0) && (&cs_n_o)); // R3
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_o) |-> !sclk_o); // R7
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) && !$past(&cs_n_o) |-> $stable(cs_n_o)); // R8
  AST_OK_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o |-> (&cs_n_o) && !$past(&cs_n_o)); // R9
  AST_DIRECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_allow_o |-> (&cs_n_o) && (io_oe_o == '0)); // R10
endmodule

// File: tb/sim_flash_map_reader.sv
module sim_flash_map_reader;
  localparam int NCS  = 3;
  localparam int HDIV = 2;
  localparam int AW   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_en = 1'b0;
  logic [2:0] route = 3'd0;
  logic [NCS*16-1:0] setup = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_err, direct_allow, sclk;
  logic [31:0] rsp_data;
  logic [NCS-1:0] cs_n;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'd0;
  logic cs_idle;

  always #4 clk = ~clk;
  assign cs_idle = &cs_n;

  flash_map_reader #(.NUM_CS(NCS), .HALF_DIV(HDIV), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .map_en_i(map_en), .cs_route_i(route),
    .setup_i(setup), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_data_o(rsp_data), .direct_allow_o(direct_allow), .sclk_o(sclk),
    .cs_n_o(cs_n), .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in));

  typedef struct { logic err; logic [31:0] data; string tag; } exp_t;
  typedef struct { logic [7:0] op; logic [31:0] addr; int nab; int nd; int lanes; int cs; } frm_t;
  exp_t sbq[$];
  frm_t fq[$];
  int checks = 0, errors = 0, frames = 0, hi_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hC3;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {byte_at(a), byte_at(a + 1), byte_at(a + 2), byte_at(a + 3)};
  endfunction

  // driver: compute expectation from requirements, then issue request
  task automatic rd(input logic [AW-1:0] a, input string tag);
    exp_t e;
    frm_t f;
    logic [15:0] s;
    logic [31:0] mask;
    bit ok;
    ok = map_en && route >= 3'd1 && int'(route) <= NCS;
    e.tag = tag;
    if (!ok) begin
      e.err = 1'b1; e.data = '0;
    end else begin
      s = setup[(int'(route) - 1) * 16 +: 16];
      f.op = s[7:0];
      f.nab = int'(s[9:8]) + 1;
      f.nd = int'(s[11:10]);
      f.lanes = (s[13:12] == 2'd1) ? 2 : (s[13:12] == 2'd3) ? 4 : 1;
      f.cs = int'(route) - 1;
      mask = (f.nab == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * f.nab)) - 32'd1);
      f.addr = 32'(a) & mask;
      e.err = 1'b0; e.data = word_at(f.addr);
      fq.push_back(f);
    end
    sbq.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (sbq.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R9", "unexpected response", 64'(rsp_data), 64'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(rsp_err == e.err, e.tag, "rsp_err", 64'(rsp_err), 64'(e.err));
          chk(rsp_data == e.data, e.tag, "rsp_data", 64'(rsp_data), 64'(e.data));
        end
      end
    end
  end

  // serial clock high-level width
  initial begin
    realtime tr;
    forever begin
      @(posedge sclk); tr = $realtime;
      @(negedge sclk);
      if ($realtime - tr != real'(HDIV * 8)) hi_bad++;
    end
  end

  // flash model
  initial begin
    forever begin
      frm_t f;
      logic [63:0] cap;
      logic [31:0] w, mask, acap;
      int txb, dc, bits, extra, k;
      bit oe_bad;
      @(negedge cs_idle);
      frames++;
      if (fq.size() == 0) begin
        chk(1'b0, "R3", "spi frame without mapped read", 64'(cs_n), 64'h7);
        @(posedge cs_idle);
        continue;
      end
      f = fq.pop_front();
      chk(cs_n == ~NCS'(1 << f.cs), "R2", "chip select line", 64'(cs_n), 64'(~NCS'(1 << f.cs)));
      txb = 8 + 8 * f.nab + 8 * f.nd;
      dc = 32 / f.lanes;
      w = word_at(f.addr);
      cap = '0; bits = 0; oe_bad = 0; extra = 0;
      while (bits < txb + dc) begin
        @(posedge sclk or posedge cs_idle);
        if (cs_idle) break;
        if (bits < txb) begin
          cap = {cap[62:0], io_out[0]};
          if (io_oe != 4'b0001) oe_bad = 1;
        end else if (io_oe != 4'b0000) oe_bad = 1;
        bits++;
        if (bits >= txb && bits < txb + dc) begin
          @(negedge sclk or posedge cs_idle);
          if (cs_idle) break;
          k = bits - txb;
          io_in = 4'd0;
          case (f.lanes)
            2: io_in[1:0] = w[31 - 2 * k -: 2];
            4: io_in = w[31 - 4 * k -: 4];
            default: io_in[1] = w[31 - k];
          endcase
        end
      end
      while (!cs_idle) begin
        @(posedge sclk or posedge cs_idle);
        if (!cs_idle) extra++;
      end
      io_in = 4'd0;
      mask = (f.nab == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * f.nab)) - 32'd1);
      acap = 32'(cap >> (8 * f.nd)) & mask;
      chk(8'(cap >> (txb - 8)) == f.op, "R4", "opcode", 64'(8'(cap >> (txb - 8))), 64'(f.op));
      chk(acap == f.addr, "R4", "address", 64'(acap), 64'(f.addr));
      chk(!oe_bad, "R4", "output enables per phase", 64'(oe_bad), 64'd0);
      chk(bits == txb + dc && extra == 0, "R5", "sclk pulse count",
          64'(bits + extra), 64'(txb + dc));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n == 3'b111, "R1", "cs in reset", 64'(cs_n), 64'h7);
    chk(!sclk && !rsp_valid, "R1", "sclk/rsp in reset", 64'({sclk, rsp_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && cs_n == 3'b111 && !sclk, "R1", "idle after reset",
        64'({req_ready, cs_n, sclk}), 64'({1'b1, 3'b111, 1'b0}));
    chk(direct_allow, "R10", "direct allowed when mode off", 64'(direct_allow), 64'd1);

    // cs0 single, 3 address bytes, no dummy
    setup[15:0]  = 16'h0203;
    // cs1 dual, 3 address bytes, 1 dummy
    setup[31:16] = 16'h163B;
    // cs2 quad, 4 address bytes, 3 dummy
    setup[47:32] = 16'h3F6B;
    map_en = 1'b1;
    @(negedge clk);
    chk(!direct_allow, "R10", "direct blocked in mapped mode", 64'(direct_allow), 64'd0);

    route = 3'd1; rd(24'h123456, "R6");
    route = 3'd2; rd(24'hABCDEF, "R5");
    route = 3'd3; rd(24'h00FFFC, "R5");
    rd(24'h765432, "R4");
    drain();
    // single address byte, lane code 2 acts as single
    setup[15:0] = 16'h2003;
    route = 3'd1; rd(24'h0000A7, "R5");
    // setup and route change while in flight
    setup[15:0] = 16'h1A0B;
    rd(24'h55AA33, "R8");
    setup[15:0] = 16'h3C9F; route = 3'd2;
    @(negedge clk);
    route = 3'd1; rd(24'h13579B, "R8");
    setup[15:0] = 16'hFFFF;
    route = 3'd3;
    // mapped read in flight: direct blocked even with mode off
    rd(24'h2468AC, "R9");
    map_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(!direct_allow, "R10", "direct blocked during read", 64'(direct_allow), 64'd0);
    chk(!req_ready, "R9", "ready low during read", 64'(req_ready), 64'd0);
    drain();
    chk(direct_allow, "R10", "direct allowed after read", 64'(direct_allow), 64'd1);

    // error paths: none of these may touch the pins
    f0 = frames;
    rd(24'h000010, "R3");
    map_en = 1'b1;
    route = 3'd0; rd(24'h000020, "R3");
    route = 3'd4; rd(24'h000030, "R2");
    route = 3'd7; rd(24'h000040, "R2");
    rd(24'h000050, "R3");
    drain();
    chk(frames == f0, "R3", "spi frames during error reads", 64'(frames), 64'(f0));
    chk(hi_bad == 0, "R7", "sclk high width errors", 64'(hi_bad), 64'd0);
    chk(fq.size() == 0 && sbq.size() == 0, "R9", "outstanding items",
        64'(fq.size() + sbq.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule